// File: doc/BRIEF.md
# Two-Step Cartridge Bank Latch

This block sits on the 8-bit CPU write bus of a cartridge and holds two bank numbers: one for a switchable 16 KiB program window and one for an 8 KiB character window. Any CPU write whose address falls in the upper half of the address space carries a command byte. Bit 7 of that byte asks for a program-bank update. Bit 6 asks for a character-bank update. The low nibble supplies the bank number, and bits 5:4 carry nothing.

A bank register takes a new value only when its request bit rises from 0 to 1 between two consecutive command writes. Software therefore issues each change as a pair: first the byte with the request bit set, then the same byte with both request bits cleared. The second write re-arms the update logic and changes nothing.

The board drives the ROM onto the data bus during the write, so the latch sees the CPU byte ANDed with the ROM byte at the write address. Software normally writes through an identity table so that both bytes agree. The program window at 0x8000-0xBFFF is fixed to bank 0. The window at 0xC000-0xFFFF follows the program bank register.

Top module: `bank_switch_latch`

## Requirements
- R1: On a synchronous active-low reset both bank outputs read 0, and both request trackers are cleared, so the first command write after reset with a request bit set loads that bank.
- R2: A write with address bit 15 equal to 0 is ignored. It changes no bank and does not alter the request trackers.
- R3: A command write whose effective bit 7 is 1, where the previous command write had effective bit 7 equal to 0, loads the program bank from effective bits 3:0.
- R4: A command write whose effective bit 6 is 1, where the previous command write had effective bit 6 equal to 0, loads the character bank from effective bits 3:0.
- R5: A command write whose request bit is 1 while the previous command write also had that bit at 1 does not reload that bank.
- R6: A command write with effective bits 7:6 equal to 00 leaves both banks unchanged and re-arms both trackers.
- R7: The effective byte is cpu_data AND rom_data. This applies to the request bits as well as the bank number.
- R8: prg_bank reads 0 when cpu_addr bit 14 is 0, and reads the program bank register when cpu_addr bit 14 is 1.
- R9: Bits 5:4 of the command byte have no effect on either bank.
- R10: A command write with both request bits rising loads both banks with the same number.
- R11: A loaded bank appears on the outputs in the first cycle after the clock edge that samples the write, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU-side clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | Write strobe, high for one cycle per CPU write |
| cpu_addr | input | 16 | CPU address, used both for write decode and for read window select |
| cpu_data | input | 8 | Byte driven by the CPU |
| rom_data | input | 8 | Byte the ROM drives at the same address (bus conflict) |
| prg_bank | output | 4 | Program bank for the current CPU address window |
| chr_bank | output | 4 | Character bank for the 8 KiB window |

## Verification
The bench focuses on the two-step sequence. It repeats a set request without an intervening clear, and a design that loads on level instead of edge would take the second number. It sends a low-address write with request bits clear between two set writes, and a decoder that let that write through would falsely re-arm the tracker and reload. It uses mismatched CPU and ROM bytes, including a ROM byte that masks a request bit, so a latch that ignores the conflict would pick the wrong bank or load when it must not. It also resets while a tracker is set, and samples just before and just after the loading edge to pin down the one-cycle latency.

// File: rtl/bank_latch_pkg.sv
// Package: shared constants for the two-step bank latch.
// Channel 0 is the program bank, channel 1 the character bank; the
// request bit of channel i is byte bit (DATA_W-1-i).
package bank_latch_pkg;
    localparam int CH_PRG   = 0;
    localparam int CH_CHR   = 1;
    localparam int NUM_CH   = 2;
endpackage

// File: rtl/bl_cmd_decode.sv
// Module: bl_cmd_decode
// Decodes a CPU write into the command window and forms the effective
// byte seen by the latch under a bus conflict (CPU byte AND ROM byte).
// Assumes the window is the upper half of the address space (top bit set).
module bl_cmd_decode #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] cpu_byte,
    input  logic [DATA_W-1:0] rom_byte,
    output logic              hit,
    output logic [DATA_W-1:0] eff_byte
);
    // Window hit and bus-conflict resolution.
    always_comb begin
        hit      = wr_en & addr[ADDR_W-1];
        eff_byte = cpu_byte & rom_byte;
    end
endmodule

// File: rtl/bl_flag_strobe.sv
// Module: bl_flag_strobe
// Tracks one request bit across command writes and pulses load when the
// bit rises from 0 to 1 between consecutive window writes.
// Assumes hit is high for exactly the cycles that carry a command write.
module bl_flag_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic flag,
    output logic load
);
    logic prev_flag;

    // Remember the request bit of the last window write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_flag <= 1'b0;
        else if (hit)
            prev_flag <= flag;
    end

    // Rising-request strobe.
    always_comb load = hit & flag & ~prev_flag;

    // A load never happens while the tracker already holds a set request.
    assert_no_level_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !prev_flag);

    // Writes outside the window leave the tracker alone.
    assert_tracker_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(prev_flag));
endmodule

// File: rtl/bl_bank_reg.sv
// Module: bl_bank_reg
// Holds one bank number; loads on a strobe, clears on reset.
module bl_bank_reg #(
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BANK_W-1:0] din,
    output logic [BANK_W-1:0] bank
);
    // Bank storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank <= '0;
        else if (load)
            bank <= din;
    end

    // Without a strobe the bank holds its value.
    assert_bank_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(bank));
endmodule

// File: rtl/bank_switch_latch.sv
// Module: bank_switch_latch (top)
// Two-step program/character bank latch on the CPU write bus. Each bank
// changes only when its request bit rises between command writes; the
// latched value reflects the bus conflict with the ROM. The low program
// window is fixed to bank 0, the high one follows the program register.
module bank_switch_latch #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic [DATA_W-1:0] rom_data,
    output logic [BANK_W-1:0] prg_bank,
    output logic [BANK_W-1:0] chr_bank
);
    import bank_latch_pkg::*;

    localparam int WIN_SEL_BIT = ADDR_W - 2;

    logic              cmd_hit;
    logic [DATA_W-1:0] cmd_byte;
    logic [NUM_CH-1:0] ch_load;
    logic [BANK_W-1:0] ch_bank [NUM_CH];

    bl_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
        .wr_en    (cpu_wr),
        .addr     (cpu_addr),
        .cpu_byte (cpu_data),
        .rom_byte (rom_data),
        .hit      (cmd_hit),
        .eff_byte (cmd_byte)
    );

    // One tracker and one register per bank channel.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        bl_flag_strobe u_strobe (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (cmd_hit),
            .flag  (cmd_byte[DATA_W-1-i]),
            .load  (ch_load[i])
        );
        bl_bank_reg #(.BANK_W(BANK_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (ch_load[i]),
            .din   (cmd_byte[BANK_W-1:0]),
            .bank  (ch_bank[i])
        );
    end

    // Window select for the program bank; character bank passes through.
    always_comb begin
        prg_bank = cpu_addr[WIN_SEL_BIT] ? ch_bank[CH_PRG] : '0;
        chr_bank = ch_bank[CH_CHR];
    end

    // Loaded program bank equals the conflicted low nibble of the write.
    assert_prg_conflict_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ch_load[CH_PRG] |=> ch_bank[CH_PRG] == $past(cpu_data[BANK_W-1:0] & rom_data[BANK_W-1:0]));

    // Fixed low window always maps to bank 0.
    assert_fixed_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_addr[WIN_SEL_BIT] |-> prg_bank == '0);

    // No bank load from a write outside the command window.
    assert_window_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && cpu_addr[ADDR_W-1]) |-> ch_load == '0);
endmodule

// File: tb/bank_switch_latch_tb.sv
module bank_switch_latch_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0] cpu_data = 8'h00;
    logic [7:0] rom_data = 8'h00;
    logic [3:0] prg_bank;
    logic [3:0] chr_bank;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    bank_switch_latch u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_data(cpu_data), .rom_data(rom_data),
        .prg_bank(prg_bank), .chr_bank(chr_bank)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One write cycle: driven at a falling edge, done at the next one.
    task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic [7:0] r);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_data = d; rom_data = r;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_addr = 16'h0000; cpu_data = 8'h00; rom_data = 8'h00;
    endtask

    task automatic cmd(input logic [7:0] d);
        wr(16'h8000 | {8'h00, d}, d, d);
    endtask

    // Read the high-window program bank through the port.
    task automatic prg_hi(output logic [3:0] v);
        cpu_addr = 16'hC000; #1; v = prg_bank; cpu_addr = 16'h0000;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [3:0] v;
        do_reset();
        prg_hi(v);
        check("R1 prg after reset", v, 4'd0);
        check("R1 chr after reset", chr_bank, 4'd0);
    endtask

    task automatic t_prg_load();
        logic [3:0] v;
        cmd(8'h85); prg_hi(v);
        check("R3 prg load", v, 4'd5);
        check("R3 chr untouched", chr_bank, 4'd0);
        cpu_addr = 16'h8000; #1;
        check("R8 low window fixed", prg_bank, 4'd0);
        cpu_addr = 16'h0000;
    endtask

    task automatic t_rearm();
        logic [3:0] v;
        cmd(8'h05); prg_hi(v);
        check("R6 clear write keeps prg", v, 4'd5);
        cmd(8'h87); prg_hi(v);
        check("R3 reload after rearm", v, 4'd7);
        cmd(8'h89); prg_hi(v);
        check("R5 no reload on held flag", v, 4'd7);
    endtask

    task automatic t_chr();
        logic [3:0] v;
        cmd(8'h00);
        check("R6 clear write keeps chr", chr_bank, 4'd0);
        cmd(8'h43); prg_hi(v);
        check("R4 chr load", chr_bank, 4'd3);
        check("R4 prg untouched", v, 4'd7);
        cmd(8'h4C);
        check("R5 chr no reload", chr_bank, 4'd3);
    endtask

    task automatic t_both();
        logic [3:0] v;
        cmd(8'h00);
        cmd(8'hCA); prg_hi(v);
        check("R10 both prg", v, 4'd10);
        check("R10 both chr", chr_bank, 4'd10);
    endtask

    task automatic t_unused();
        logic [3:0] v;
        cmd(8'h30); prg_hi(v);
        check("R9 unused bits prg", v, 4'd10);
        check("R9 unused bits chr", chr_bank, 4'd10);
        cmd(8'hB2); prg_hi(v);
        check("R9 prg load ignores 5:4", v, 4'd2);
    endtask

    task automatic t_window();
        logic [3:0] v;
        wr(16'h7000, 8'h00, 8'h00);
        cmd(8'h84); prg_hi(v);
        check("R2 low write did not rearm", v, 4'd2);
        cmd(8'h00);
        wr(16'h6000, 8'h8F, 8'hFF); prg_hi(v);
        check("R2 low write no load", v, 4'd2);
    endtask

    task automatic t_conflict();
        logic [3:0] v;
        cmd(8'h00);
        wr(16'h8123, 8'h8F, 8'hF3); prg_hi(v);
        check("R7 conflicted bank", v, 4'd3);
        cmd(8'h00);
        wr(16'h8200, 8'h8C, 8'h7F); prg_hi(v);
        check("R7 masked flag no load", v, 4'd3);
    endtask

    task automatic t_latency();
        logic [3:0] v;
        cmd(8'h00);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = 16'hC006; cpu_data = 8'h86; rom_data = 8'h86;
        #8;
        check("R11 old value before edge", prg_bank, 4'd3);
        @(negedge clk);
        cpu_wr = 1'b0;
        check("R11 new value after edge", prg_bank, 4'd6);
        cpu_addr = 16'h0000;
        prg_hi(v);
    endtask

    task automatic t_reset_mid();
        logic [3:0] v;
        do_reset();
        prg_hi(v);
        check("R1 mid reset prg", v, 4'd0);
        cmd(8'h81); prg_hi(v);
        check("R1 tracker cleared by reset", v, 4'd1);
    endtask

    initial begin
        t_reset();
        t_prg_load();
        t_rearm();
        t_chr();
        t_both();
        t_unused();
        t_window();
        t_conflict();
        t_latency();
        t_reset_mid();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule